// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Inserter

This block sits in the transmit path of a T1 interface. It takes the serial stream of 193-bit frames, one bit per clock: a framing bit followed by 24 timeslots of eight bits each, with bit 1 of each timeslot sent first. In every sixth frame of the 24-frame multiframe it replaces the last bit of each timeslot with a channel-associated signaling bit. A sync pulse on the transmit system clock marks the framing bit of frame 1. The block's own counters carry the frame and multiframe position between pulses.

The signaling bits come from one of two sources. One is a serial signaling input. It is sampled in the last frame of each multiframe and held for the whole of the following multiframe. The other is a bank of twelve 8-bit signaling registers, supplied as a flat input vector. When both sources are enabled, the register bank wins. When the serial source is enabled, the framing bit is also taken from the serial signaling input. A per-timeslot clear-channel mask leaves chosen timeslots untouched in either mode. Every output bit leaves through exactly one register stage.

Top module: `rbs_inserter`

## Requirements
- R1: `sync_i` high marks the framing bit of frame 1. A frame is 193 clocks long and a multiframe is 24 frames; the counters free-run between pulses, and a pulse arriving at any point realigns them. Until the first pulse after reset, no bit is replaced.
- R2: Outside the inserted positions, `data_o` equals `data_i` from one clock earlier.
- R3: In frames 6, 12, 18 and 24, the eighth bit (the last one sent) of each timeslot carries signaling bit A, B, C or D, in that order.
- R4: With `int_en_i` high, the signaling bits come from `sig_store_i`. Byte k (bits 8k+7..8k) serves timeslots 2k+1 and 2k+2. Bits 8k+7..8k+4 hold A,B,C,D of timeslot 2k+1, and bits 8k+3..8k hold A,B,C,D of timeslot 2k+2.
- R5: With both `int_en_i` and `ext_en_i` high, the register-bank bits are inserted and the serial signaling bits are not.
- R6: With `ext_en_i` high, the values of `xsig_i` in bit positions 5, 6, 7 and 8 of each timeslot during frame 24 are captured as A, B, C and D. They are inserted throughout the following multiframe.
- R7: `xsig_i` in bit positions 1 to 4 of a timeslot, and `xsig_i` in any frame other than frame 24, has no effect on the inserted bits.
- R8: With `ext_en_i` high, the framing-bit position of `data_o` carries `xsig_i` from the framing-bit clock. Otherwise the framing bit passes from `data_i`.
- R9: `clear_mask_i` bit n high (bit 0 being timeslot 1) keeps timeslot n+1 unchanged in every mode.
- R10: With both enables low, `data_o` is `data_i` delayed by one clock in every position.
- R11: Reset drives `data_o` low and clears the captured serial signaling bits to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | transmit system clock |
| rst_n | input | 1 | active-low synchronous reset |
| sync_i | input | 1 | high on the framing bit of frame 1 |
| data_i | input | 1 | serial transmit payload |
| xsig_i | input | 1 | serial signaling and framing-bit input |
| ext_en_i | input | 1 | enable the serial signaling source |
| int_en_i | input | 1 | enable the register-bank source (takes priority) |
| sig_store_i | input | 96 | twelve signaling bytes, two timeslots per byte |
| clear_mask_i | input | 24 | per-timeslot clear-channel enable |
| data_o | output | 1 | serial transmit output |

## Verification
Every output bit is due on the clock edge after the input bit it derives from. The bench drives at a falling edge and compares `data_o` at the next falling edge, so each check sees exactly one register stage. The serial signaling nibble has a longer delay: it is captured in frame 24 and first appears in frame 6 of the following multiframe. The bench models that delay with its own shadow and active copies, and checks the inserted bits a full multiframe after capture. The framing bit and the pass-through positions are compared on the same one-clock delay.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   localparam int SIG_BITS = 4;

   typedef logic [SIG_BITS-1:0] sig_nib_t;
   typedef logic [1:0]          sig_sel_t;

   // A sits in the top nibble bit, D in bit 0
   function automatic logic sig_pick(input sig_nib_t nib, input sig_sel_t sel);
      return nib[2'd3 - sel];
   endfunction
endpackage

// File: rtl/rbs_frame_timer.sv
module rbs_frame_timer #(
   parameter int NUM_TS     = 24,
   parameter int TS_BITS    = 8,
   parameter int SIG_PERIOD = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sync_i,
   output logic                        cur_fbit,
   output logic [$clog2(NUM_TS)-1:0]   cur_ts,
   output logic [$clog2(TS_BITS)-1:0]  cur_bit,
   output logic                        cur_sig_frame,
   output logic                        cur_last_frame,
   output logic                        cur_mf_start,
   output rbs_pkg::sig_sel_t           cur_sig_sel,
   output logic                        cur_locked
);
   localparam int FRAME_BITS = 1 + NUM_TS * TS_BITS;
   localparam int POS_W      = $clog2(FRAME_BITS);
   localparam int TS_W       = $clog2(NUM_TS);
   localparam int BIT_W      = $clog2(TS_BITS);
   localparam int SUB_W      = (SIG_PERIOD > 1) ? $clog2(SIG_PERIOD) : 1;

   logic [POS_W-1:0]  pos_q, cur_pos, pos_n;
   logic [TS_W-1:0]   ts_q, ts_n;
   logic [BIT_W-1:0]  bit_q, bit_n;
   logic [SUB_W-1:0]  sub_q, cur_sub, sub_n;
   rbs_pkg::sig_sel_t grp_q, grp_n;
   logic              locked_q;
   logic              frame_end;

   // a sync pulse forces the present clock to frame 1, framing bit
   always_comb begin
      cur_pos     = sync_i ? '0 : pos_q;
      cur_ts      = sync_i ? '0 : ts_q;
      cur_bit     = sync_i ? '0 : bit_q;
      cur_sub     = sync_i ? '0 : sub_q;
      cur_sig_sel = sync_i ? '0 : grp_q;
      cur_locked  = sync_i | locked_q;
   end

   assign cur_fbit       = (cur_pos == '0);
   assign frame_end      = (cur_pos == POS_W'(FRAME_BITS - 1));
   assign cur_sig_frame  = (cur_sub == SUB_W'(SIG_PERIOD - 1));
   assign cur_last_frame = cur_sig_frame && (cur_sig_sel == 2'd3);
   assign cur_mf_start   = cur_fbit && (cur_sub == '0) && (cur_sig_sel == 2'd0);

   always_comb begin
      pos_n = frame_end ? '0 : cur_pos + 1'b1;
      ts_n  = cur_ts;
      bit_n = cur_bit;
      if (cur_fbit) begin
         ts_n  = '0;
         bit_n = '0;
      end else if (cur_bit == BIT_W'(TS_BITS - 1)) begin
         bit_n = '0;
         ts_n  = (cur_ts == TS_W'(NUM_TS - 1)) ? '0 : cur_ts + 1'b1;
      end else begin
         bit_n = cur_bit + 1'b1;
      end
      sub_n = cur_sub;
      grp_n = cur_sig_sel;
      if (frame_end) begin
         if (cur_sig_frame) begin
            sub_n = '0;
            grp_n = cur_sig_sel + 2'd1;
         end else begin
            sub_n = cur_sub + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q    <= '0;
         ts_q     <= '0;
         bit_q    <= '0;
         sub_q    <= '0;
         grp_q    <= '0;
         locked_q <= 1'b0;
      end else begin
         pos_q    <= pos_n;
         ts_q     <= ts_n;
         bit_q    <= bit_n;
         sub_q    <= sub_n;
         grp_q    <= grp_n;
         locked_q <= cur_locked;
      end
   end
endmodule

// File: rtl/rbs_ext_sig.sv
module rbs_ext_sig #(
   parameter int NUM_TS  = 24,
   parameter int TS_BITS = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cap_en,
   input  logic                            mf_start,
   input  logic [$clog2(NUM_TS)-1:0]       cur_ts,
   input  logic [$clog2(TS_BITS)-1:0]      cur_bit,
   input  logic                            xsig_i,
   output logic [rbs_pkg::SIG_BITS*NUM_TS-1:0] active_o
);
   localparam int TS_W      = $clog2(NUM_TS);
   localparam int BIT_W     = $clog2(TS_BITS);
   localparam int FIRST_CAP = TS_BITS - rbs_pkg::SIG_BITS;

   logic       cap_hit;
   logic [1:0] lane;

   // only the last four bit positions of a timeslot are latched
   assign cap_hit = cap_en && (cur_bit >= BIT_W'(FIRST_CAP));
   assign lane    = 2'(BIT_W'(TS_BITS - 1) - cur_bit);

   for (genvar g = 0; g < NUM_TS; g++) begin : g_slot
      rbs_pkg::sig_nib_t shadow_q, active_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
         end else begin
            if (cap_hit && cur_ts == TS_W'(g))
               shadow_q[lane] <= xsig_i;
            if (mf_start)
               active_q <= shadow_q;
         end
      end
      assign active_o[rbs_pkg::SIG_BITS*g +: rbs_pkg::SIG_BITS] = active_q;
   end
endmodule

// File: rtl/rbs_int_sig.sv
module rbs_int_sig #(
   parameter int NUM_TS = 24
) (
   input  logic [rbs_pkg::SIG_BITS*NUM_TS-1:0] store_i,
   input  logic [$clog2(NUM_TS)-1:0]           ts_i,
   output rbs_pkg::sig_nib_t                   nib_o
);
   localparam int TS_W = $clog2(NUM_TS);

   // the first timeslot of a pair sits in the upper nibble of its byte
   always_comb begin
      nib_o = '0;
      for (int k = 0; k < NUM_TS; k++)
         if (ts_i == TS_W'(k))
            nib_o = store_i[rbs_pkg::SIG_BITS*(k ^ 1) +: rbs_pkg::SIG_BITS];
   end
endmodule

// File: rtl/rbs_inserter.sv
module rbs_inserter #(
   parameter int NUM_TS      = 24,
   parameter int TS_BITS     = 8,
   parameter int SIG_PERIOD  = 6,
   parameter bit FS_FROM_EXT = 1'b1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               sync_i,
   input  logic                               data_i,
   input  logic                               xsig_i,
   input  logic                               ext_en_i,
   input  logic                               int_en_i,
   input  logic [rbs_pkg::SIG_BITS*NUM_TS-1:0] sig_store_i,
   input  logic [NUM_TS-1:0]                  clear_mask_i,
   output logic                               data_o
);
   localparam int TS_W  = $clog2(NUM_TS);
   localparam int BIT_W = $clog2(TS_BITS);

   if (NUM_TS < 2 || (NUM_TS % 2) != 0) begin : g_bad_ts
      $error("NUM_TS must be even and at least 2");
   end
   if (TS_BITS < rbs_pkg::SIG_BITS) begin : g_bad_bits
      $error("TS_BITS must hold the four latched positions");
   end
   if (SIG_PERIOD < 1) begin : g_bad_period
      $error("SIG_PERIOD must be positive");
   end

   logic              cur_fbit, cur_sig_frame, cur_last_frame, cur_mf_start, cur_locked;
   logic [TS_W-1:0]   cur_ts;
   logic [BIT_W-1:0]  cur_bit;
   rbs_pkg::sig_sel_t cur_sig_sel;
   logic [rbs_pkg::SIG_BITS*NUM_TS-1:0] ext_active;
   rbs_pkg::sig_nib_t int_nib, ext_nib, sig_nib;
   logic              cap_en, slot_hit, fbit_take, next_bit;

   rbs_frame_timer #(.NUM_TS(NUM_TS), .TS_BITS(TS_BITS), .SIG_PERIOD(SIG_PERIOD)) u_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .sync_i        (sync_i),
      .cur_fbit      (cur_fbit),
      .cur_ts        (cur_ts),
      .cur_bit       (cur_bit),
      .cur_sig_frame (cur_sig_frame),
      .cur_last_frame(cur_last_frame),
      .cur_mf_start  (cur_mf_start),
      .cur_sig_sel   (cur_sig_sel),
      .cur_locked    (cur_locked)
   );

   assign cap_en = ext_en_i && cur_locked && cur_last_frame && !cur_fbit;

   rbs_ext_sig #(.NUM_TS(NUM_TS), .TS_BITS(TS_BITS)) u_ext (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (cap_en),
      .mf_start(cur_mf_start),
      .cur_ts  (cur_ts),
      .cur_bit (cur_bit),
      .xsig_i  (xsig_i),
      .active_o(ext_active)
   );

   rbs_int_sig #(.NUM_TS(NUM_TS)) u_int (
      .store_i(sig_store_i),
      .ts_i   (cur_ts),
      .nib_o  (int_nib)
   );

   always_comb begin
      ext_nib = '0;
      for (int k = 0; k < NUM_TS; k++)
         if (cur_ts == TS_W'(k))
            ext_nib = ext_active[rbs_pkg::SIG_BITS*k +: rbs_pkg::SIG_BITS];
   end

   assign sig_nib  = int_en_i ? int_nib : ext_nib;
   assign slot_hit = cur_locked && !cur_fbit && cur_sig_frame
                  && (cur_bit == BIT_W'(TS_BITS - 1))
                  && (int_en_i || ext_en_i) && !clear_mask_i[cur_ts];

   if (FS_FROM_EXT) begin : g_fs_ext
      assign fbit_take = cur_locked && cur_fbit && ext_en_i;
   end else begin : g_fs_pass
      assign fbit_take = 1'b0;
   end

   always_comb begin
      if (fbit_take)     next_bit = xsig_i;
      else if (slot_hit) next_bit = rbs_pkg::sig_pick(sig_nib, cur_sig_sel);
      else               next_bit = data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) data_o <= 1'b0;
      else        data_o <= next_bit;
   end
endmodule

// File: rtl/rbs_inserter_chk.sv
module rbs_inserter_chk #(
   parameter int NUM_TS      = 24,
   parameter int TS_BITS     = 8,
   parameter bit FS_FROM_EXT = 1'b1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       data_i,
   input logic                       data_o,
   input logic                       xsig_i,
   input logic                       ext_en_i,
   input logic                       int_en_i,
   input logic [NUM_TS-1:0]          clear_mask_i,
   input logic                       cur_fbit,
   input logic                       cur_locked,
   input logic                       cur_sig_frame,
   input logic [$clog2(NUM_TS)-1:0]  cur_ts,
   input logic [$clog2(TS_BITS)-1:0] cur_bit
);
   localparam int BIT_W = $clog2(TS_BITS);

   logic at_sig_pos;
   assign at_sig_pos = cur_sig_frame && (cur_bit == BIT_W'(TS_BITS - 1));

   // R1: nothing is replaced before the first sync pulse
   p_prelock_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_locked |=> data_o == $past(data_i));

   // R2: ordinary payload positions are delayed by one clock
   p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_locked && !cur_fbit && !at_sig_pos) |=> data_o == $past(data_i));

   // R9: clear-channel slots are never touched
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cur_fbit && clear_mask_i[cur_ts]) |=> data_o == $past(data_i));

   // R10: no source enabled means plain delay
   p_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_en_i && !ext_en_i) |=> data_o == $past(data_i));

   if (FS_FROM_EXT) begin : g_fs_chk
      // R8: framing bit comes from the serial signaling input
      p_fbit_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (cur_locked && cur_fbit && ext_en_i) |=> data_o == $past(xsig_i));
   end
endmodule

bind rbs_inserter rbs_inserter_chk #(
   .NUM_TS(NUM_TS), .TS_BITS(TS_BITS), .FS_FROM_EXT(FS_FROM_EXT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .data_i       (data_i),
   .data_o       (data_o),
   .xsig_i       (xsig_i),
   .ext_en_i     (ext_en_i),
   .int_en_i     (int_en_i),
   .clear_mask_i (clear_mask_i),
   .cur_fbit     (cur_fbit),
   .cur_locked   (cur_locked),
   .cur_sig_frame(cur_sig_frame),
   .cur_ts       (cur_ts),
   .cur_bit      (cur_bit)
);

// File: tb/tb_rbs_inserter.sv
module tb_rbs_inserter;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_TS     = 24;
   localparam int FRAME_LEN  = 193;
   localparam int MF_FRAMES  = 24;
   localparam int MF_LEN     = FRAME_LEN * MF_FRAMES;

   typedef struct packed {
      logic        int_en;
      logic        ext_en;
      logic [1:0]  xmode;
      logic [23:0] clr;
      logic [7:0]  dseed;
      logic [7:0]  xseed;
      logic [31:0] store;
      logic [1:0]  n_mf;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 1'b0, 2'd0, 24'h000000, 8'h13, 8'h5B, 32'h00000000, 2'd1},
      '{1'b1, 1'b0, 2'd0, 24'h000000, 8'h27, 8'h3C, 32'hA5C396F0, 2'd1},
      '{1'b0, 1'b1, 2'd0, 24'h000000, 8'h41, 8'h9E, 32'h00000000, 2'd2},
      '{1'b1, 1'b1, 2'd0, 24'h000000, 8'h66, 8'hD1, 32'h1E2D3C4B, 2'd1},
      '{1'b1, 1'b0, 2'd0, 24'hA50F31, 8'h72, 8'h08, 32'hFFFF0000, 2'd1},
      '{1'b0, 1'b1, 2'd0, 24'h5AF0CE, 8'h8B, 8'h77, 32'h00000000, 2'd2}
   };

   logic clk = 1'b0;
   logic rst_n, sync_i, data_i, xsig_i, ext_en_i, int_en_i, data_o;
   logic [95:0] sig_store_i;
   logic [23:0] clear_mask_i;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // bench-side model state
   int   mpos, mfrm;
   bit   mlocked;
   logic [3:0] m_shadow [NUM_TS];
   logic [3:0] m_active [NUM_TS];

   always #(CLK_PERIOD/2) clk = ~clk;

   rbs_inserter dut (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .data_i(data_i), .xsig_i(xsig_i),
      .ext_en_i(ext_en_i), .int_en_i(int_en_i), .sig_store_i(sig_store_i),
      .clear_mask_i(clear_mask_i), .data_o(data_o)
   );

   function automatic logic pat(input int f, input int p, input logic [7:0] seed);
      int v;
      v = f * 31 + p * 17 + int'(seed);
      return v[2] ^ v[0] ^ v[5];
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s frame=%0d pos=%0d actual=%b expected=%b", req, mfrm, mpos, act, exp);
      end
   endtask

   task automatic run(input vec_t v, input int n_cyc, input bit do_sync, input string tag);
      int_en_i     = v.int_en;
      ext_en_i     = v.ext_en;
      clear_mask_i = v.clr;
      sig_store_i  = {3{v.store}};
      for (int c = 0; c < n_cyc; c++) begin
         logic d, x, e;
         int ts, b, s;
         string req;
         sync_i = 1'b0;
         if (c == 0 && do_sync) begin
            sync_i  = 1'b1;
            mpos    = 0;
            mfrm    = 0;
            mlocked = 1'b1;
         end
         ts = (mpos - 1) / 8;
         b  = (mpos - 1) % 8;
         s  = mfrm / 6;
         d  = pat(mfrm, mpos, v.dseed);
         if (v.xmode == 2'd1)
            x = (mfrm == 23 && mpos != 0 && b >= 4) ? 1'b0 : 1'b1;
         else
            x = pat(mfrm + 3, mpos, v.xseed);
         if (mpos == 0 && mfrm == 0)
            for (int k = 0; k < NUM_TS; k++) m_active[k] = m_shadow[k];
         e   = d;
         req = "R2";
         if (!mlocked) begin
            req = "R1";
         end else if (mpos == 0) begin
            req = "R8";
            if (v.ext_en) e = x;
         end else if (b == 7 && (mfrm % 6) == 5) begin
            if (v.clr[ts])                   req = "R9";
            else if (!v.int_en && !v.ext_en) req = "R10";
            else if (v.int_en) begin
               req = v.ext_en ? "R5" : "R4";
               e   = sig_store_i[4 * (ts ^ 1) + 3 - s];
            end else begin
               req = (s == 0) ? "R3" : "R6";
               e   = m_active[ts][3 - s];
            end
         end
         if (tag != "") req = tag;
         if (mlocked && v.ext_en && mfrm == 23 && mpos != 0 && b >= 4)
            m_shadow[ts][7 - b] = x;
         data_i = d;
         xsig_i = x;
         @(negedge clk);
         check(req, data_o, e);
         mpos++;
         if (mpos == FRAME_LEN) begin
            mpos = 0;
            mfrm = (mfrm + 1) % MF_FRAMES;
         end
      end
      sync_i = 1'b0;
   endtask

   initial begin
      vec_t dv;
      for (int k = 0; k < NUM_TS; k++) begin
         m_shadow[k] = '0;
         m_active[k] = '0;
      end
      mpos = 0; mfrm = 0; mlocked = 1'b0;
      rst_n = 1'b0; sync_i = 1'b0; data_i = 1'b1; xsig_i = 1'b1;
      ext_en_i = 1'b1; int_en_i = 1'b1; sig_store_i = '1; clear_mask_i = '0;
      repeat (3) @(negedge clk);
      check("R11", data_o, 1'b0);
      rst_n = 1'b1;

      // R1: before the first sync pulse every bit passes unchanged
      dv = '{1'b1, 1'b1, 2'd0, 24'h0, 8'h35, 8'hC2, 32'hFFFFFFFF, 2'd1};
      run(dv, 500, 1'b0, "R1");

      for (int i = 0; i < NVEC; i++)
         run(VEC[i], MF_LEN * int'(VEC[i].n_mf), 1'b1, "");

      // R7: stray serial bits outside frame 24 positions 5..8 are dropped
      dv = '{1'b0, 1'b1, 2'd1, 24'h0, 8'h59, 8'h00, 32'h0, 2'd2};
      run(dv, MF_LEN * 2, 1'b1, "R7");

      // R1: a pulse in mid-frame realigns the counters
      dv = '{1'b1, 1'b0, 2'd0, 24'h0, 8'h1D, 8'h44, 32'h6C93B27E, 2'd1};
      run(dv, 3001, 1'b1, "R1");
      run(dv, MF_LEN, 1'b1, "R1");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule